// File: doc/BRIEF.md
# User-State Access Region Guard

This block watches every access a processor makes on its bus and decides, in the same cycle, whether a user-state access breaks the rules set for the running task. Software loads up to eight address windows through a small write port. Each window has a lower bound, an upper bound and three attribute bits: enable, deny-write and deny-fetch. A fixed peripheral address window is also guarded. User code may touch it only when a control bit grants that access.

The decision is registered, so the violation strobe appears one clock after the access. Any violation also raises a non-maskable interrupt request. That request holds until software clears it. The first offending address and its access kind are frozen for the handler to read. Supervisor-state accesses are never checked. Task switching, arbitration and interrupt delivery belong to the surrounding system.

Top module: `mpu_guard`

## Requirements
- R1: Each of the eight windows is loaded through the write port. `cfg_idx` selects the window and `cfg_kind` selects the field: 0 is the lower bound, 1 is the upper bound and 2 is the attributes. For the attributes, bit 0 is enable, bit 1 is deny-write and bit 2 is deny-fetch. A write takes effect for accesses in the following cycle.
- R2: Bounds are compared on an 8-byte grain. The lower bound rounds down to a multiple of 8 and the upper bound rounds up to the last byte of its 8-byte block. Both ends are inclusive.
- R3: A valid user-state write that lands in an enabled window with deny-write set is a violation. A read of the same window is not a violation.
- R4: A valid user-state fetch from an enabled window with deny-fetch set is a violation.
- R5: A window whose enable bit is clear never matches, whatever its other bits are. An access outside every enabled window and outside the peripheral window is allowed. When windows overlap, any one matching window that forbids the access makes it a violation.
- R6: Accesses in supervisor state (`acc_super`=1) never cause a violation. This includes accesses to the peripheral window.
- R7: A valid user-state access whose byte address lies in the peripheral window (PERIPH_LO..PERIPH_HI, by default 0x000000..0x0007FF) is a violation unless the user-peripheral grant is set. The grant is written with `cfg_kind`=3, bit 0 of `cfg_wdata`.
- R8: `viol_q` is high during exactly the one cycle after a violating access. It stays low after any cycle with `acc_valid` low.
- R9: `nmi_req` is set by a violation and stays high until a cycle with `clr_nmi` high. If a violation and a clear arrive in the same cycle, the violation wins and `nmi_req` stays set.
- R10: A violation that arrives while `nmi_req` is low, or in the same cycle as a clear, stores its address, write flag and fetch flag in `cap_addr`, `cap_write` and `cap_fetch`. Violations while `nmi_req` stays set leave those values unchanged.
- R11: After reset, all windows are disabled and the peripheral grant is clear. `viol_q`, `nmi_req`, `cap_addr`, `cap_write` and `cap_fetch` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window number for a configuration write |
| cfg_kind | input | 2 | Field selector: lower bound, upper bound, attributes, control |
| cfg_wdata | input | 23 | Configuration write data |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | 23 | Byte address of the access |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor state |
| clr_nmi | input | 1 | Software clear of the sticky request |
| viol_q | output | 1 | Registered one-cycle violation strobe |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |
| cap_addr | output | 23 | Address of the first unhandled violation |
| cap_write | output | 1 | Write flag of the captured violation |
| cap_fetch | output | 1 | Fetch flag of the captured violation |

## Verification
Directed accesses probe the first and last bytes of a window programmed with unaligned bounds, and the bytes just outside it. These show whether rounding and inclusive limits are right. Reads, writes and fetches are sent to the same deny-write and deny-fetch windows in both privilege states, so an attribute applied to the wrong access kind or the wrong state shows up. A disabled window, the peripheral window with and without the grant, and a clear arriving together with a fresh violation are each tried on their own. Random accesses then run against randomly programmed, often overlapping windows, and a bench model predicts the strobe, the sticky request and the captured fields.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef struct packed {
    logic nx;
    logic nw;
    logic en;
  } win_attr_t;

  typedef enum logic [1:0] {
    CFG_LO   = 2'd0,
    CFG_HI   = 2'd1,
    CFG_ATTR = 2'd2,
    CFG_CTRL = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 23,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDXW-1:0]          cfg_idx,
  input  logic [1:0]               cfg_kind,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [NREG-1:0][AW-1:0]  win_lo,
  output logic [NREG-1:0][AW-1:0]  win_hi,
  output win_attr_t [NREG-1:0]     win_attr,
  output logic                     periph_grant
);
  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_lo[i]   <= '0;
        win_hi[i]   <= '0;
        win_attr[i] <= '0;
      end else if (sel) begin
        case (cfg_kind)
          CFG_LO:   win_lo[i]   <= cfg_wdata;
          CFG_HI:   win_hi[i]   <= cfg_wdata;
          CFG_ATTR: win_attr[i] <= win_attr_t'(cfg_wdata[2:0]);
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) periph_grant <= 1'b0;
    else if (cfg_we && cfg_kind == CFG_CTRL) periph_grant <= cfg_wdata[0];
  end
endmodule

// File: rtl/mpu_region_cmp.sv
module mpu_region_cmp
  import mpu_pkg::*;
#(
  parameter int AW = 23,
  parameter int GB = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          is_write,
  input  logic          is_fetch,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  win_attr_t     attr,
  output logic          hit,
  output logic          deny
);
  // Block number of a byte address on the comparison grain.
  function automatic logic [AW-1:0] grain_of(input logic [AW-1:0] a);
    return a >> GB;
  endfunction

  function automatic logic in_span(input logic [AW-1:0] a,
                                   input logic [AW-1:0] l,
                                   input logic [AW-1:0] h);
    return (grain_of(a) >= grain_of(l)) && (grain_of(a) <= grain_of(h));
  endfunction

  assign hit  = attr.en && in_span(addr, lo, hi);
  assign deny = hit && ((attr.nw && is_write) || (attr.nx && is_fetch));
endmodule

// File: rtl/mpu_viol_latch.sv
module mpu_viol_latch #(
  parameter int AW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol_now,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          acc_fetch,
  input  logic          clr_nmi,
  output logic          viol_q,
  output logic          nmi_req,
  output logic [AW-1:0] cap_addr,
  output logic          cap_write,
  output logic          cap_fetch
);
  logic cap_open;
  assign cap_open = viol_now && (!nmi_req || clr_nmi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q    <= 1'b0;
      nmi_req   <= 1'b0;
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_fetch <= 1'b0;
    end else begin
      viol_q  <= viol_now;
      nmi_req <= viol_now || (nmi_req && !clr_nmi);
      if (cap_open) begin
        cap_addr  <= acc_addr;
        cap_write <= acc_write;
        cap_fetch <= acc_fetch;
      end
    end
  end

  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && !clr_nmi |=> nmi_req);
  a_r9_strobe_raises: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> nmi_req);
  a_r10_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && !clr_nmi |=> $stable(cap_addr) && $stable(cap_write) && $stable(cap_fetch));
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int              NREG      = 8,
  parameter int              AW        = 23,
  parameter int              GB        = 3,
  parameter logic [AW-1:0]   PERIPH_LO = 23'h000000,
  parameter logic [AW-1:0]   PERIPH_HI = 23'h0007FF,
  localparam int             IDXW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [1:0]      cfg_kind,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_write,
  input  logic            acc_fetch,
  input  logic            acc_super,
  input  logic            clr_nmi,
  output logic            viol_q,
  output logic            nmi_req,
  output logic [AW-1:0]   cap_addr,
  output logic            cap_write,
  output logic            cap_fetch
);
  logic [NREG-1:0][AW-1:0] win_lo, win_hi;
  win_attr_t [NREG-1:0]    win_attr;
  logic                    periph_grant;
  logic [NREG-1:0]         win_hit, win_deny;
  logic                    user_acc, periph_hit, periph_bad, region_bad, viol_now;

  mpu_region_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .win_lo(win_lo),
    .win_hi(win_hi), .win_attr(win_attr), .periph_grant(periph_grant)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    mpu_region_cmp #(.AW(AW), .GB(GB)) u_cmp (
      .addr(acc_addr), .is_write(acc_write), .is_fetch(acc_fetch),
      .lo(win_lo[i]), .hi(win_hi[i]), .attr(win_attr[i]),
      .hit(win_hit[i]), .deny(win_deny[i])
    );
  end

  assign user_acc   = acc_valid && !acc_super;
  assign periph_hit = (acc_addr >= PERIPH_LO) && (acc_addr <= PERIPH_HI);
  assign periph_bad = periph_hit && !periph_grant;
  assign region_bad = |win_deny;
  assign viol_now   = user_acc && (region_bad || periph_bad);

  mpu_viol_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .viol_now(viol_now), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .clr_nmi(clr_nmi),
    .viol_q(viol_q), .nmi_req(nmi_req), .cap_addr(cap_addr),
    .cap_write(cap_write), .cap_fetch(cap_fetch)
  );

  a_r6_super_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_super |=> !viol_q);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !viol_q);
  a_r5_deny_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (win_deny & ~win_hit) == '0);
  a_r3_read_no_region_fault: assert property (@(posedge clk) disable iff (!rst_n)
    user_acc && !acc_write && !acc_fetch && !periph_hit |=> !viol_q);
endmodule

// File: tb/sim_mpu_guard.sv
`timescale 1ns/100ps
module sim_mpu_guard;
  localparam int AW = 23;
  localparam logic [AW-1:0] PLO = 23'h000000;
  localparam logic [AW-1:0] PHI = 23'h0007FF;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [1:0] cfg_kind = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0, clr_nmi = 0;
  logic [AW-1:0] acc_addr = 0;
  logic viol_q, nmi_req, cap_write, cap_fetch;
  logic [AW-1:0] cap_addr;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_lo [8], m_hi [8];
  logic m_en [8], m_nw [8], m_nx [8];
  logic m_pok = 0, m_nmi = 0, m_cw = 0, m_cf = 0;
  logic [AW-1:0] m_caddr = 0;

  always #2.5 clk = ~clk;

  mpu_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_super(acc_super), .clr_nmi(clr_nmi), .viol_q(viol_q),
    .nmi_req(nmi_req), .cap_addr(cap_addr), .cap_write(cap_write),
    .cap_fetch(cap_fetch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inclusive 8-byte blocks: byte addr lies in [lo & ~7, hi | 7].
  function automatic logic exp_viol(input logic [AW-1:0] a, input logic w,
                                    input logic f, input logic s);
    logic v = 0;
    if (s) return 0;
    for (int i = 0; i < 8; i++)
      if (m_en[i] && a >= (m_lo[i] & ~23'd7) && a <= (m_hi[i] | 23'd7) &&
          ((m_nw[i] && w) || (m_nx[i] && f))) v = 1;
    if (a >= PLO && a <= PHI && !m_pok) v = 1;
    return v;
  endfunction

  task automatic cfg(input int idx, input logic [1:0] kind, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[2:0]; cfg_kind = kind; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    case (kind)
      2'd0: m_lo[idx] = d;
      2'd1: m_hi[idx] = d;
      2'd2: begin m_en[idx] = d[0]; m_nw[idx] = d[1]; m_nx[idx] = d[2]; end
      default: m_pok = d[0];
    endcase
  endtask

  task automatic win(input int idx, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                     input logic [2:0] attr);
    cfg(idx, 2'd0, lo); cfg(idx, 2'd1, hi); cfg(idx, 2'd2, {20'd0, attr});
  endtask

  task automatic acc(input string req, input logic [AW-1:0] a, input logic w,
                     input logic f, input logic s, input logic v, input logic clr);
    logic e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w; acc_fetch = f; acc_super = s; clr_nmi = clr;
    e = v && exp_viol(a, w, f, s);
    @(posedge clk); #1;
    acc_valid = 0; clr_nmi = 0;
    if (e && (!m_nmi || clr)) begin m_caddr = a; m_cw = w; m_cf = f; end
    m_nmi = e || (m_nmi && !clr);
    chk({req, " viol_q"}, {31'd0, viol_q}, {31'd0, e});
    chk({req, " nmi_req"}, {31'd0, nmi_req}, {31'd0, m_nmi});
    chk({req, " cap"}, {7'd0, cap_addr, cap_write, cap_fetch}, {7'd0, m_caddr, m_cw, m_cf});
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_en[i] = 0; m_nw[i] = 0; m_nx[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset", {27'd0, viol_q, nmi_req, cap_write, cap_fetch, |cap_addr}, 32'd0);
    rst_n = 1;
    // R5 nothing enabled: write outside peripheral window allowed
    acc("R5 empty", 23'h4000, 1, 0, 0, 1, 0);
    // R11 peripheral grant clear after reset -> R7 user peripheral access faults
    acc("R7 periph no grant", 23'h000100, 0, 0, 0, 1, 0);
    acc("R9 clear", 23'h4000, 0, 0, 0, 0, 1);
    // R1 R3 deny-write window
    win(0, 23'h1000, 23'h10FF, 3'b011);
    acc("R3 write", 23'h1050, 1, 0, 0, 1, 1);
    acc("R3 read ok", 23'h1050, 0, 0, 0, 1, 1);
    acc("R8 strobe drops", 23'h1050, 0, 0, 0, 0, 0);
    // R2 unaligned bounds -> bytes 0x2000..0x200F
    win(1, 23'h2003, 23'h2009, 3'b011);
    acc("R2 first byte", 23'h2000, 1, 0, 0, 1, 1);
    acc("R2 last byte", 23'h200F, 1, 0, 0, 1, 1);
    acc("R2 below", 23'h1FFF, 1, 0, 0, 1, 1);
    acc("R2 above", 23'h2010, 1, 0, 0, 1, 1);
    // R4 deny-fetch
    win(2, 23'h3000, 23'h30FF, 3'b101);
    acc("R4 fetch", 23'h3010, 0, 1, 0, 1, 1);
    acc("R4 write ok", 23'h3010, 1, 0, 0, 1, 1);
    // R5 disabled window with deny bits
    win(3, 23'h5000, 23'h50FF, 3'b110);
    acc("R5 disabled", 23'h5008, 1, 1, 0, 1, 1);
    // R6 supervisor bypass
    acc("R6 super write", 23'h1050, 1, 0, 1, 1, 1);
    acc("R6 super periph", 23'h000200, 0, 0, 1, 1, 0);
    // R8 invalid access quiet
    acc("R8 not valid", 23'h1050, 1, 0, 0, 0, 0);
    // R10 first capture then frozen
    acc("R10 first", 23'h1004, 1, 0, 0, 1, 0);
    acc("R10 second frozen", 23'h3020, 0, 1, 0, 1, 0);
    acc("R9 held", 23'h6000, 0, 0, 0, 1, 0);
    // R9 set wins over clear, R10 capture on clear
    acc("R9 set wins", 23'h3030, 0, 1, 0, 1, 1);
    acc("R9 clear", 23'h6000, 0, 0, 0, 1, 1);
    // R7 grant
    cfg(0, 2'd3, 23'd1);
    acc("R7 granted", 23'h000100, 1, 0, 0, 1, 0);
    acc("R7 top edge", 23'h0007FF, 0, 1, 0, 1, 0);
    cfg(0, 2'd3, 23'd0);
    acc("R7 last byte", 23'h0007FF, 0, 0, 0, 1, 0);
    acc("R7 past window", 23'h000800, 0, 0, 0, 1, 1);
    // Random: overlapping windows, mixed accesses
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 8; i++) begin
        logic [AW-1:0] lo;
        lo = 23'($urandom_range(0, 23'h7F00));
        win(i, lo, lo + 23'($urandom_range(0, 23'h0400)), 3'($urandom));
      end
      cfg(0, 2'd3, 23'($urandom_range(0, 1)));
      for (int k = 0; k < 40; k++)
        acc("R5 random", 23'($urandom_range(0, 23'h8400)), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) != 0),
            ($urandom_range(0, 5) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule